// File: doc/BRIEF.md
# SPI Shared-Pin Port Override

This block is the steering logic for a four-pin general-purpose port whose pins are borrowed by a serial peripheral interface (SPI) unit. It also carries a divided CPU clock output and two external interrupt lines. Software sets one direction bit and one port bit per pin. The SPI unit supplies its enable, its master/slave role and its three output signals. From these, the block works out each pin's output enable, the value the pin drives and whether its pull-up is on.

Depending on the SPI role, some pins are forced to be inputs. A pin that is not forced follows its direction bit. A forced pin keeps its pull-up under the control of its port bit. The block also returns the pin levels to the SPI unit and to the interrupt logic, and reports when a selected slave is active.

Pin roles, by index: bit 3 is master-in/slave-out, bit 2 is master-out/slave-in, bit 1 is the serial clock and bit 0 is the slave select. While the SPI is off, bit 0 can instead output a divide-by-two copy of the clock.

Top module: `spi_pin_mux`

## Requirements
- R1: With `spi_en`=1 and `spi_master`=1, `pad_oe[3]` is 0 whatever `dir_bits[3]` holds, and `pad_oe[2:0]` equals `dir_bits[2:0]`.
- R2: With `spi_en`=1 and `spi_master`=0, `pad_oe[2:0]` is 0 whatever the direction bits hold, and `pad_oe[3]` equals `dir_bits[3]`.
- R3: With `spi_en`=0, `pad_oe` equals `dir_bits`, except that pin 0 is governed by R7 while `clkout_en`=1.
- R4: `pad_pu[i]` is 1 exactly when `pad_oe[i]`=0 and `port_bits[i]`=1. This holds for both forced and software-selected inputs.
- R5: On an output pin, the driven value follows the SPI role. In master mode pin 2 drives `spi_mosi_out` and pin 1 drives `spi_sck_out`. In slave mode pin 3 drives `spi_miso_out`. Every other output pin drives its `port_bits` bit. `pad_out[i]` is 0 whenever `pad_oe[i]` is 0.
- R6: `slave_active` is 1 exactly when `spi_en`=1, `spi_master`=0 and `pin_in[0]`=0.
- R7: With `spi_en`=0 and `clkout_en`=1, `pad_oe[0]`=1 and `pad_out[0]` carries a divider bit. That bit is 0 in reset and inverts on every rising clock edge after reset. `clkout_en` has no effect while `spi_en`=1.
- R8: With `spi_en`=0, `ext_irq2`=`pin_in[3]` and `ext_irq1`=`pin_in[2]`. With `spi_en`=1, both are held at 1 (inactive).
- R9: `spi_miso_in`=`pin_in[3]`, `spi_mosi_in`=`pin_in[2]` and `spi_sck_in`=`pin_in[1]` at all times.
- R10: While `rst_n`=0, the divider bit is 0, so pin 0 with the clock output selected drives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| dir_bits | input | 4 | Per-pin direction, 1 = output |
| port_bits | input | 4 | Per-pin output value / pull-up request |
| pin_in | input | 4 | Pin levels from the pads |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | 1 = master role, 0 = slave role |
| spi_sck_out | input | 1 | Serial clock from the SPI core |
| spi_mosi_out | input | 1 | Master-out data from the SPI core |
| spi_miso_out | input | 1 | Slave-out data from the SPI core |
| clkout_en | input | 1 | Select divided clock on pin 0 |
| pad_oe | output | 4 | Per-pin output enable |
| pad_out | output | 4 | Per-pin driven value |
| pad_pu | output | 4 | Per-pin pull-up enable |
| spi_sck_in | output | 1 | Serial clock level to the SPI core |
| spi_mosi_in | output | 1 | Master-out line level to the SPI core |
| spi_miso_in | output | 1 | Slave-out line level to the SPI core |
| slave_active | output | 1 | Slave selected |
| ext_irq1 | output | 1 | External interrupt 1 level |
| ext_irq2 | output | 1 | External interrupt 2 level |

## Verification
The assertions check three invariants on every cycle: a forced pin never drives, and a pull-up is never on at a driving pin. An input pin always shows a 0 data value. In addition, the interrupt lines sit at 1 while the SPI is on, the divider inverts each cycle and slave activity implies a low select pin. Only the bench scenarios can show that the right source reaches each output pin in each role. The same holds for the exact divider phase after reset and for `clkout_en` losing its effect while the SPI owns the pins.

// File: rtl/spi_pin_pkg.sv
package spi_pin_pkg;
  localparam int NPINS = 4;
  // Pin roles by index: 3 = MISO, 2 = MOSI, 1 = SCK, 0 = select / clock out
  localparam logic [NPINS-1:0] FORCE_IN_MST = 4'b1000;
  localparam logic [NPINS-1:0] FORCE_IN_SLV = 4'b0111;
  localparam logic [NPINS-1:0] DRIVE_MST    = 4'b0110;
  localparam logic [NPINS-1:0] DRIVE_SLV    = 4'b1000;
  localparam logic [NPINS-1:0] CLKOUT_PIN   = 4'b0001;
endpackage

// File: rtl/spi_pin_lane.sv
module spi_pin_lane #(
  parameter bit FORCE_MST = 1'b0,
  parameter bit FORCE_SLV = 1'b0,
  parameter bit DRV_MST   = 1'b0,
  parameter bit DRV_SLV   = 1'b0,
  parameter bit CLKO_CAP  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_en,
  input  logic spi_master,
  input  logic dir,
  input  logic port,
  input  logic spi_val,
  input  logic clkout_act,
  input  logic clkout_val,
  output logic oe,
  output logic out,
  output logic pu
);
  logic forced, drv_spi, clk_own, val;

  always_comb begin
    forced  = spi_en & (spi_master ? FORCE_MST : FORCE_SLV);
    drv_spi = spi_en & (spi_master ? DRV_MST : DRV_SLV);
    clk_own = CLKO_CAP & clkout_act;
    oe      = clk_own | (~forced & dir);
    if (clk_own)      val = clkout_val;
    else if (drv_spi) val = spi_val;
    else              val = port;
    out = oe & val;
    pu  = ~oe & port;
  end

  // R1 / R2: a pin owned as input by the SPI never drives
  a_r1_forced_input: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master && FORCE_MST) || (spi_en && !spi_master && FORCE_SLV) |-> !oe);
  a_r4_pullup_input_only: assert property (@(posedge clk) disable iff (!rst_n)
    pu |-> !oe);
  a_r5_quiet_input: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !out);
endmodule

// File: rtl/spi_clkout_div2.sv
module spi_clkout_div2 (
  input  logic clk,
  input  logic rst_n,
  output logic q
);
  logic q_next;

  always_comb q_next = ~q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_next;
  end

  a_r7_div_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (q != $past(q)));
endmodule

// File: rtl/spi_pin_inroute.sv
module spi_pin_inroute #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             spi_en,
  input  logic             spi_master,
  output logic             spi_sck_in,
  output logic             spi_mosi_in,
  output logic             spi_miso_in,
  output logic             slave_active,
  output logic             ext_irq1,
  output logic             ext_irq2
);
  always_comb begin
    spi_miso_in  = pin_in[3];
    spi_mosi_in  = pin_in[2];
    spi_sck_in   = pin_in[1];
    slave_active = spi_en & ~spi_master & ~pin_in[0];
    ext_irq2     = spi_en ? 1'b1 : pin_in[3];
    ext_irq1     = spi_en ? 1'b1 : pin_in[2];
  end

  a_r8_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en |-> (ext_irq1 && ext_irq2));
  a_r6_select_low: assert property (@(posedge clk) disable iff (!rst_n)
    slave_active |-> (!pin_in[0] && !spi_master));
endmodule

// File: rtl/spi_pin_mux.sv
module spi_pin_mux
  import spi_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] dir_bits,
  input  logic [NPINS-1:0] port_bits,
  input  logic [NPINS-1:0] pin_in,
  input  logic             spi_en,
  input  logic             spi_master,
  input  logic             spi_sck_out,
  input  logic             spi_mosi_out,
  input  logic             spi_miso_out,
  input  logic             clkout_en,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_pu,
  output logic             spi_sck_in,
  output logic             spi_mosi_in,
  output logic             spi_miso_in,
  output logic             slave_active,
  output logic             ext_irq1,
  output logic             ext_irq2
);
  logic [NPINS-1:0] spi_drv;
  logic             div_q;
  logic             clkout_act;

  assign spi_drv    = {spi_miso_out, spi_mosi_out, spi_sck_out, 1'b0};
  assign clkout_act = ~spi_en & clkout_en;

  spi_clkout_div2 u_div (.clk(clk), .rst_n(rst_n), .q(div_q));

  for (genvar i = 0; i < NPINS; i++) begin : g_lane
    spi_pin_lane #(
      .FORCE_MST(FORCE_IN_MST[i]), .FORCE_SLV(FORCE_IN_SLV[i]),
      .DRV_MST(DRIVE_MST[i]), .DRV_SLV(DRIVE_SLV[i]), .CLKO_CAP(CLKOUT_PIN[i])
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .spi_master(spi_master),
      .dir(dir_bits[i]), .port(port_bits[i]), .spi_val(spi_drv[i]),
      .clkout_act(clkout_act), .clkout_val(div_q),
      .oe(pad_oe[i]), .out(pad_out[i]), .pu(pad_pu[i])
    );
  end

  spi_pin_inroute #(.NPINS(NPINS)) u_in (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .spi_en(spi_en),
    .spi_master(spi_master), .spi_sck_in(spi_sck_in), .spi_mosi_in(spi_mosi_in),
    .spi_miso_in(spi_miso_in), .slave_active(slave_active),
    .ext_irq1(ext_irq1), .ext_irq2(ext_irq2)
  );

  a_r7_clkout_drives: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_act |-> pad_oe[0]);
endmodule

// File: tb/spi_pin_mux_test.sv
module spi_pin_mux_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] dir_bits, port_bits, pin_in;
  logic spi_en, spi_master, spi_sck_out, spi_mosi_out, spi_miso_out, clkout_en;
  logic [3:0] pad_oe, pad_out, pad_pu;
  logic spi_sck_in, spi_mosi_in, spi_miso_in, slave_active, ext_irq1, ext_irq2;
  logic ref_div;
  int n_chk = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ref_div <= 1'b0; else ref_div <= ~ref_div;

  spi_pin_mux uut (.*);

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_oe();
    logic [3:0] o = dir_bits;
    if (spi_en && spi_master) o[3] = 1'b0;
    if (spi_en && !spi_master) o[2:0] = 3'b000;
    if (!spi_en && clkout_en) o[0] = 1'b1;
    return o;
  endfunction

  function automatic logic [3:0] exp_out();
    logic [3:0] v = port_bits;
    logic [3:0] o = exp_oe();
    if (spi_en && spi_master) begin v[2] = spi_mosi_out; v[1] = spi_sck_out; end
    if (spi_en && !spi_master) v[3] = spi_miso_out;
    if (!spi_en && clkout_en) v[0] = ref_div;
    return v & o;
  endfunction

  task automatic check_all();
    string mode;
    mode = !spi_en ? "R3" : (spi_master ? "R1" : "R2");
    if (!spi_en && clkout_en) begin
      chk("R7 clkout", {3'b0, pad_oe[0]}, 4'b0001);
    end
    chk(mode, pad_oe, exp_oe());
    chk("R5", pad_out, exp_out());
    chk("R4", pad_pu, port_bits & ~exp_oe());
    chk("R6", {3'b0, slave_active}, {3'b0, spi_en & ~spi_master & ~pin_in[0]});
    chk("R8", {2'b0, ext_irq2, ext_irq1}, spi_en ? 4'b0011 : {2'b0, pin_in[3], pin_in[2]});
    chk("R9", {1'b0, spi_miso_in, spi_mosi_in, spi_sck_in}, {1'b0, pin_in[3:1]});
  endtask

  task automatic step(input logic [3:0] d, input logic [3:0] p, input logic [3:0] pi,
                      input logic en, input logic m, input logic [2:0] so, input logic ce);
    @(posedge clk); #1;
    dir_bits = d; port_bits = p; pin_in = pi; spi_en = en; spi_master = m;
    {spi_miso_out, spi_mosi_out, spi_sck_out} = so; clkout_en = ce;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    dir_bits = 4'hF; port_bits = 4'h0; pin_in = 4'h0; spi_en = 1'b0; spi_master = 1'b0;
    {spi_miso_out, spi_mosi_out, spi_sck_out} = 3'b111; clkout_en = 1'b1;
    repeat (3) @(negedge clk);
    // R10: divider held at 0 in reset
    chk("R10", {3'b0, pad_out[0]}, 4'b0000);
    chk("R10 oe", {3'b0, pad_oe[0]}, 4'b0001);
    @(negedge clk); rst_n = 1'b1;
    // R7: phase sequence 1,0,1,0 after release
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 phase", {3'b0, pad_out[0]}, {3'b0, (k % 2 == 0)});
    end
    // directed corners
    step(4'hF, 4'hF, 4'h0, 1'b1, 1'b1, 3'b111, 1'b1); // R1 master, clkout ignored
    step(4'hF, 4'hF, 4'h0, 1'b1, 1'b0, 3'b111, 1'b1); // R2 slave, select low
    step(4'h0, 4'hF, 4'h1, 1'b1, 1'b0, 3'b000, 1'b0); // R4 forced pull-ups
    step(4'h0, 4'h5, 4'hC, 1'b0, 1'b0, 3'b000, 1'b0); // R8 irq from pins
    step(4'hE, 4'hA, 4'h3, 1'b0, 1'b1, 3'b101, 1'b1); // R7 clkout on pin 0
    for (int k = 0; k < 400; k++)
      step($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule